// File: doc/BRIEF.md
# Overlapped Register Window File

This block is the general register file of a small RISC core that uses rotating register windows. Software names sixteen logical registers, a0 to a15. A window base pointer, counted in groups of four registers ("quads"), maps them onto a larger physical array. The physical address is the base times four plus the logical index, modulo the array size. The array holds 32 or 64 entries, chosen by a parameter.

A call names a rotation of one, two or three quads (4, 8 or 12 registers). The call saves a return value into the caller's register at the rotation distance, and carries the rotation code in the top two bits of that value. The callee's entry operation then advances the base by the pending rotation. Caller and callee therefore share their overlapping registers, so arguments pass with no copying. A windowed return reads the code from the current a0 and moves the base back by the same amount.

A bitmap records which quads hold live frame data. The block raises a one-cycle overflow flag when an entry claims a quad that an older frame still holds. It raises a one-cycle underflow flag when a return exposes a hidden quad that a wrapped frame has overwritten. The spill and fill work itself is left to software handlers.

Top module: `regwin_file`

## Requirements
- R1: A logical index i reads and writes physical entry (4*base + i) mod NPHYS. After a 4-register rotation, the caller's a6 and a7 read as the callee's a2 and a3.
- R2: A call with code k (1, 2, 3 meaning 4, 8, 12 registers) writes {k, ret[DW-3:0]} into the caller's logical register a(4k). The code sits in the two most significant bits. The callee sees this value as its a0 after entry.
- R3: An entry advances win_base by the code of the most recent call, modulo NPHYS/4. The new base is visible in the cycle after the entry.
- R4: A return reads the code from the top two bits of the current a0 and lowers win_base by that many quads. A code of 0 leaves the base unchanged.
- R5: Registers hidden by a rotation keep their values across the call and its return.
- R6: overflow is high for exactly the one cycle after an entry whose newly claimed quads include a quad still live. The rotation still takes place.
- R7: underflow is high for exactly the one cycle after a return whose re-exposed hidden quads include a quad no longer live. The rotation still takes place, and those quads count as live afterwards.
- R8: After reset, win_base is 0, both flags are 0, quads 0 to 3 are live and the pending code is 0. An entry before any call leaves the base at 0.
- R9: The read ports are combinational. A write lands at the clock edge and reads back from the next cycle. When call_en and wr_en are high in the same cycle, only the call's write happens.
- R10: When entry_en and ret_en are high in the same cycle, the entry is performed and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_a_data | output | DW | Read data, port A |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_b_data | output | DW | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Logical write index |
| wr_data | input | DW | Write data |
| call_en | input | 1 | Call: record the code and save the return value |
| call_inc | input | 2 | Rotation code, 1 to 3 quads |
| call_ret | input | DW | Return value; its top two bits are replaced by the code |
| entry_en | input | 1 | Rotate forward by the pending code |
| ret_en | input | 1 | Rotate back by the code held in a0 |
| win_base | output | WBW | Current window base, in quads |
| overflow | output | 1 | One-cycle flag: a live quad was claimed |
| underflow | output | 1 | One-cycle flag: a re-exposed quad was not live |

## Verification
At base 0, all sixteen logical registers are written with distinct values and read back through both ports. This shows that the mapping is the identity with no aliasing. A single 4-register call shows the argument overlap, the saved code in a0 and the preservation of hidden registers. These are three separate outcomes of the same rotation. A chain of five 12-register calls on the 64-entry array wraps the window. It shows exactly where overflow appears, and the matching chain of returns shows where underflow appears. Collisions of entry with return and of call with write, plus a return that carries code 0, check the priority rules and the no-move case.

// File: rtl/regwin_file.sv
module regwin_file #(
  parameter int NPHYS = 64,
  parameter int DW = 32,
  localparam int WBW = $clog2(NPHYS / 4)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     rd_a_idx,
  output logic [DW-1:0]  rd_a_data,
  input  logic [3:0]     rd_b_idx,
  output logic [DW-1:0]  rd_b_data,
  input  logic           wr_en,
  input  logic [3:0]     wr_idx,
  input  logic [DW-1:0]  wr_data,
  input  logic           call_en,
  input  logic [1:0]     call_inc,
  input  logic [DW-1:0]  call_ret,
  input  logic           entry_en,
  input  logic           ret_en,
  output logic [WBW-1:0] win_base,
  output logic           overflow,
  output logic           underflow
);
  localparam int NQ  = NPHYS / 4;
  localparam int PAW = WBW + 2;

  logic [DW-1:0]  rf [NPHYS];
  logic [WBW-1:0] wb;
  logic [1:0]     pend;
  logic [NQ-1:0]  live, claim, rel, tgt;
  logic [1:0]     ret_code;
  logic           do_ret;

  function automatic logic [PAW-1:0] map(input logic [WBW-1:0] b, input logic [3:0] i);
    return {b, 2'b00} + PAW'(i);
  endfunction

  assign rd_a_data = rf[map(wb, rd_a_idx)];
  assign rd_b_data = rf[map(wb, rd_b_idx)];
  assign ret_code  = rf[map(wb, 4'd0)][DW-1 -: 2];
  assign do_ret    = ret_en && !entry_en;
  assign win_base  = wb;

  always_comb begin
    claim = '0;
    rel   = '0;
    tgt   = '0;
    for (int j = 0; j < 3; j++) begin
      if (j < int'(pend)) claim[WBW'(int'(wb) + 4 + j)] = 1'b1;
      if (j < int'(ret_code)) begin
        rel[WBW'(int'(wb) + 4 - int'(ret_code) + j)] = 1'b1;
        tgt[WBW'(int'(wb) - int'(ret_code) + j)]     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (call_en)
      rf[map(wb, {call_inc, 2'b00})] <= {call_inc, call_ret[DW-3:0]};
    else if (wr_en)
      rf[map(wb, wr_idx)] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb        <= '0;
      pend      <= '0;
      live      <= NQ'(4'hF);
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      overflow  <= 1'b0;
      underflow <= 1'b0;
      if (call_en) pend <= call_inc;
      if (entry_en) begin
        wb       <= wb + WBW'(pend);
        live     <= live | claim;
        overflow <= |(live & claim);
      end else if (do_ret) begin
        wb        <= wb - WBW'(ret_code);
        live      <= (live & ~rel) | tgt;
        underflow <= |(tgt & ~live);
      end
    end
  end

  a_r3_entry_step: assert property (@(posedge clk) disable iff (!rst_n)
    entry_en |=> win_base == $past(WBW'(win_base + WBW'(pend))));
  a_r4_ret_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_en && !entry_en) |=> win_base == $past(WBW'(win_base - WBW'(ret_code))));
  a_r10_entry_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_en && ret_en) |=> !underflow);
  a_r6_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(entry_en));
  a_r7_unf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> $past(ret_en && !entry_en));
  a_r5_window_live: assert property (@(posedge clk) disable iff (!rst_n)
    live[wb] && live[WBW'(int'(wb) + 1)] && live[WBW'(int'(wb) + 2)] && live[WBW'(int'(wb) + 3)]);
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(overflow && underflow));
endmodule

// File: tb/test_regwin_file.sv
module test_regwin_file;
  logic clk = 0, rst_n = 0;
  logic [3:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = 0, call_ret = 0;
  logic wr_en = 0, call_en = 0, entry_en = 0, ret_en = 0;
  logic [1:0] call_inc = 0;
  logic [3:0] win_base;
  logic overflow, underflow;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  regwin_file i_regwin_file (.clk, .rst_n, .rd_a_idx, .rd_a_data, .rd_b_idx, .rd_b_data,
    .wr_en, .wr_idx, .wr_data, .call_en, .call_inc, .call_ret, .entry_en, .ret_en,
    .win_base, .overflow, .underflow);

  localparam logic [35:0] VEC [16] = '{
    {4'd0, 32'h0000_1000}, {4'd1, 32'h1111_0001}, {4'd2, 32'h2222_0002}, {4'd3, 32'h3333_0003},
    {4'd4, 32'h4444_0004}, {4'd5, 32'h5555_0005}, {4'd6, 32'h6666_0006}, {4'd7, 32'h7777_0007},
    {4'd8, 32'h8888_0008}, {4'd9, 32'h9999_0009}, {4'd10, 32'hAAAA_000A}, {4'd11, 32'hBBBB_000B},
    {4'd12, 32'hCCCC_000C}, {4'd13, 32'hDDDD_000D}, {4'd14, 32'hEEEE_000E}, {4'd15, 32'hFFFF_000F}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
    wr_en = 0; call_en = 0; entry_en = 0; ret_en = 0;
  endtask

  task automatic wr(input logic [3:0] i, input logic [31:0] d);
    wr_en = 1; wr_idx = i; wr_data = d; step();
  endtask

  task automatic rd(input string req, input logic [3:0] i, input logic [31:0] exp);
    rd_a_idx = i; rd_b_idx = i; #1;
    check(req, rd_a_data, exp);
    check(req, rd_b_data, exp);
  endtask

  task automatic do_call(input logic [1:0] k, input logic [31:0] r);
    call_en = 1; call_inc = k; call_ret = r; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2;
    repeat (2) step();
    rst_n = 1;
    check("R8 base", 32'(win_base), 0);
    check("R8 ovf", 32'(overflow), 0);
    check("R8 unf", 32'(underflow), 0);
    entry_en = 1; step();
    check("R8 entry without call", 32'(win_base), 0);

    for (int n = 0; n < 16; n++) wr(VEC[n][35:32], VEC[n][31:0]);
    for (int n = 0; n < 16; n++) rd("R1 identity map", VEC[n][35:32], VEC[n][31:0]);

    ret_en = 1; step();
    check("R4 code zero no move", 32'(win_base), 0);
    check("R7 code zero no flag", 32'(underflow), 0);

    wr(4'd2, 32'h0000_0022);
    wr(4'd6, 32'h0000_0066);
    wr(4'd7, 32'h0000_0077);
    call_en = 1; call_inc = 2'd1; call_ret = 32'hC000_0100;
    wr_en = 1; wr_idx = 4'd4; wr_data = 32'hDEAD_BEEF; step();
    rd("R9 call beats write", 4'd4, 32'h4000_0100);
    rd("R2 code in caller a4", 4'd4, 32'h4000_0100);
    entry_en = 1; step();
    check("R3 base after entry", 32'(win_base), 1);
    rd("R1 caller a6 as a2", 4'd2, 32'h0000_0066);
    rd("R1 caller a7 as a3", 4'd3, 32'h0000_0077);
    rd("R2 callee a0", 4'd0, 32'h4000_0100);
    wr(4'd2, 32'h0000_005A);
    rd("R9 write visible next cycle", 4'd2, 32'h0000_005A);
    ret_en = 1; step();
    check("R4 base after return", 32'(win_base), 0);
    rd("R1 callee a2 as caller a6", 4'd6, 32'h0000_005A);
    rd("R5 hidden a2 kept", 4'd2, 32'h0000_0022);
    rd("R5 hidden a1 kept", 4'd1, 32'h1111_0001);
    check("R6 no ovf", 32'(overflow), 0);

    do_call(2'd2, 32'h0000_0200);
    entry_en = 1; ret_en = 1; step();
    check("R10 entry wins", 32'(win_base), 2);
    check("R10 no underflow", 32'(underflow), 0);
    ret_en = 1; step();
    check("R4 return by 8", 32'(win_base), 0);

    for (int d = 0; d < 5; d++) begin
      do_call(2'd3, 32'h0000_1000 + 32'(d));
      entry_en = 1; step();
      check("R3 deep base", 32'(win_base), 32'((3 * (d + 1)) % 16));
      check("R6 overflow at wrap", 32'(overflow), (d == 4) ? 1 : 0);
    end
    step();
    check("R6 overflow one cycle", 32'(overflow), 0);
    for (int d = 4; d >= 0; d--) begin
      ret_en = 1; step();
      check("R4 deep return base", 32'(win_base), 32'(3 * d));
      check("R7 underflow at unwind", 32'(underflow), (d == 0) ? 1 : 0);
    end
    step();
    check("R7 underflow one cycle", 32'(underflow), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule